// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Updates

This block generates four independent pulse-width modulated outputs under the control of a simple 32-bit memory-mapped register bus. Each channel has its own 16-bit up-counter. The counter runs at the input clock divided by a power of two that the channel selects, and counts through one period after another. A compare against the channel's duty value sets the output level. A polarity bit can invert that level.

Software starts and stops channels through two shared write-one registers, one that sets enables and one that clears them. A shared status register reports which channels are running. While a channel is stopped, its duty and period registers are written directly. While it runs, direct writes are refused. New values are then written to an update location and held as pending. A pending value is copied into the working register only when the channel counter wraps, so that no period is ever cut short or stretched midway.

A build parameter chooses between two layouts of the channel window. In layout 1 there is a single update location, and a mode bit steers it to duty or to period. In layout 2 duty and period each have a dedicated update location.

Top module: `pwm_bank`

## Requirements
- R1: Channel c (0 to 3) owns a window at byte address 0x200 + 0x20*c. Offset 0x00 of the window is the mode register, with prescaler select in bits [3:0], polarity in bit 9 and update target in bit 10. The mode register reads back as written in those bits and as zero elsewhere.
- R2: A write to address 0x000 sets the enable of every channel whose data bit (bit c for channel c) is 1. Bits that are 0 leave the enable unchanged.
- R3: A write to address 0x004 clears the enable of every channel whose data bit is 1. Bits that are 0 leave the enable unchanged.
- R4: Reading address 0x008 returns the four enables in bits [3:0] (0x0F when all channels run). All enables are 0 after reset.
- R5: A running channel advances its counter once every 2^N clock cycles, where N is the prescaler select. A select above 10 acts as 10. The counter counts 0, 1, ..., P-1 and then returns to 0, where P is the period. A period of 0 keeps the counter at 0.
- R6: While running with polarity 0, the output is 0 while the counter is below the duty value and 1 otherwise. Polarity 1 inverts the output.
- R7: A stopped channel drives its output to the value of its polarity bit and holds its counter at 0. A restart therefore begins at count 0.
- R8: Duty and period hold 16 bits. Bits 31:16 of a write to them are discarded.
- R9: Duty is at offset 0x04. Period is at offset 0x08 in layout 1 and at 0x0C in layout 2. Writes to these offsets take effect at once on a stopped channel and are ignored on a running one.
- R10: In layout 1, offset 0x10 is the update location: it goes to duty when mode bit 10 is 0 and to period when it is 1. In layout 2, offset 0x08 updates duty and offset 0x10 updates period.
- R11: On a running channel, an update write is held as pending. It replaces the working value at the first counter wrap that follows the clock edge capturing the write. On a stopped channel, an update write replaces the working value at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The bench builds two copies side by side, each with the default four channels, 16-bit counters and a largest prescale exponent of 10. One copy uses layout 1 and the other layout 2, so that both the mode-steered update and the two dedicated update locations are reached, along with each layout's own period offset. The 4-bit prescaler field can hold a value above 10, which brings the clamp within reach; a two-count period at that setting spans 2048 cycles and is traced sample by sample. Update writes land in the middle of a period, and the bench predicts the wrap at which each one takes effect.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // Global register addresses
  localparam int unsigned ADDR_ENA  = 32'h000;
  localparam int unsigned ADDR_DIS  = 32'h004;
  localparam int unsigned ADDR_STAT = 32'h008;

  // Channel windows
  localparam int unsigned WIN_BASE  = 32'h200;
  localparam int unsigned WIN_SHIFT = 5;

  // Offsets inside a channel window
  localparam int unsigned OFS_MODE        = 32'h00;
  localparam int unsigned OFS_DUTY        = 32'h04;
  localparam int unsigned V1_OFS_PRD      = 32'h08;
  localparam int unsigned V1_OFS_UPD      = 32'h10;
  localparam int unsigned V2_OFS_DUTY_UPD = 32'h08;
  localparam int unsigned V2_OFS_PRD      = 32'h0C;
  localparam int unsigned V2_OFS_PRD_UPD  = 32'h10;

  // Mode register fields
  localparam int unsigned PRES_W   = 4;
  localparam int unsigned MODE_POL = 9;
  localparam int unsigned MODE_TGT = 10;

  function automatic logic [PRES_W-1:0] pres_clamp(input logic [PRES_W-1:0] sel,
                                                   input int unsigned lim);
    return (32'(sel) > lim) ? PRES_W'(lim) : sel;
  endfunction

  function automatic logic [31:0] last_count(input logic [31:0] prd);
    return (prd == 32'd0) ? 32'd0 : prd - 32'd1;
  endfunction

  function automatic logic out_level(input logic [31:0] cnt, input logic [31:0] duty,
                                     input logic pol);
    return (cnt >= duty) ^ pol;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_bank_pkg::*;
#(
  parameter int unsigned PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRES_W-1:0] sel,
  output logic              tick
);
  localparam int unsigned DIVW = (PRES_MAX < 1) ? 1 : PRES_MAX;

  logic [DIVW-1:0]   div_q;
  logic [DIVW-1:0]   mask;
  logic [PRES_W-1:0] sel_eff;

  always_comb begin
    sel_eff = pres_clamp(sel, PRES_MAX);
    mask    = DIVW'((33'd1 << sel_eff) - 33'd1);
    tick    = run && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_bank_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] prd,
  output logic [DW-1:0] cnt,
  output logic          wrap
);
  logic [DW-1:0] last;

  always_comb begin
    last = DW'(last_count(32'(prd)));
    wrap = tick && (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (wrap)      cnt <= '0;
    else if (tick)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int unsigned VARIANT  = 1,
  parameter int unsigned DW       = 16,
  parameter int unsigned PRES_MAX = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr,
  input  logic [4:0]    ofs,
  input  logic [DW-1:0] wval,
  output logic [31:0]   rdata,
  output logic          pwm_o,
  output logic          pol_o,
  output logic          wrap_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] prd_o
);
  localparam logic [4:0] O_MODE = 5'(OFS_MODE);
  localparam logic [4:0] O_DUTY = 5'(OFS_DUTY);
  localparam logic [4:0] O_PRD  = 5'((VARIANT == 1) ? V1_OFS_PRD : V2_OFS_PRD);
  localparam logic [4:0] O_DUPD = 5'((VARIANT == 1) ? V1_OFS_UPD : V2_OFS_DUTY_UPD);
  localparam logic [4:0] O_PUPD = 5'((VARIANT == 1) ? V1_OFS_UPD : V2_OFS_PRD_UPD);

  logic [PRES_W-1:0] pres;
  logic              pol, tgt;
  logic [DW-1:0]     duty, prd;
  logic [DW-1:0]     pend_duty, pend_prd;
  logic              pend_duty_f, pend_prd_f;
  logic              route_duty, route_prd;
  logic              hit_dupd, hit_pupd, tick, wrap;
  logic [DW-1:0]     cnt;

  // Layout choice: a steered single update location or two dedicated ones
  generate
    if (VARIANT == 1) begin : g_steered
      assign route_duty = !tgt;
      assign route_prd  = tgt;
    end else begin : g_split
      assign route_duty = 1'b1;
      assign route_prd  = 1'b1;
    end
  endgenerate

  assign hit_dupd = wr && (ofs == O_DUPD) && route_duty;
  assign hit_pupd = wr && (ofs == O_PUPD) && route_prd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres <= '0; pol <= 1'b0; tgt <= 1'b0;
      duty <= '0; prd <= '0;
      pend_duty <= '0; pend_prd <= '0;
      pend_duty_f <= 1'b0; pend_prd_f <= 1'b0;
    end else begin
      if (wr && ofs == O_MODE) begin
        pres <= wval[PRES_W-1:0];
        pol  <= wval[MODE_POL];
        tgt  <= wval[MODE_TGT];
      end
      if (wr && ofs == O_DUTY && !run) duty <= wval;
      if (wr && ofs == O_PRD  && !run) prd  <= wval;
      // boundary copy first, so a same-cycle update write stays pending
      if (wrap && pend_duty_f) begin duty <= pend_duty; pend_duty_f <= 1'b0; end
      if (wrap && pend_prd_f)  begin prd  <= pend_prd;  pend_prd_f  <= 1'b0; end
      if (hit_dupd) begin
        if (!run) begin duty <= wval; pend_duty_f <= 1'b0; end
        else      begin pend_duty <= wval; pend_duty_f <= 1'b1; end
      end
      if (hit_pupd) begin
        if (!run) begin prd <= wval; pend_prd_f <= 1'b0; end
        else      begin pend_prd <= wval; pend_prd_f <= 1'b1; end
      end
    end
  end

  pwm_prescaler #(.PRES_MAX(PRES_MAX)) u_pres (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(pres), .tick(tick)
  );

  pwm_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .prd(prd), .cnt(cnt), .wrap(wrap)
  );

  always_comb begin
    rdata = '0;
    if (ofs == O_MODE) begin
      rdata[PRES_W-1:0] = pres;
      rdata[MODE_POL]   = pol;
      rdata[MODE_TGT]   = tgt;
    end else if (ofs == O_DUTY) rdata[DW-1:0] = duty;
    else if (ofs == O_PRD)      rdata[DW-1:0] = prd;
    else if (ofs == O_DUPD && route_duty) rdata[DW-1:0] = pend_duty;
    else if (ofs == O_PUPD)     rdata[DW-1:0] = pend_prd;
  end

  assign pwm_o  = run ? out_level(32'(cnt), 32'(duty), pol) : pol;
  assign pol_o  = pol;
  assign wrap_o = wrap;
  assign cnt_o  = cnt;
  assign prd_o  = prd;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned DW       = 16,
  parameter int unsigned PRES_MAX = 10,
  parameter int unsigned VARIANT  = 1,
  parameter int unsigned AW       = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int unsigned IDXW    = AW - WIN_SHIFT;
  localparam int unsigned WIN_END = WIN_BASE + NCH * (1 << WIN_SHIFT);

  logic [NCH-1:0]          ch_en;
  logic [NCH-1:0]          ch_pol;
  logic [NCH-1:0]          ch_wrap;
  logic [NCH-1:0][DW-1:0]  ch_cnt;
  logic [NCH-1:0][DW-1:0]  ch_prd;
  logic [NCH-1:0][31:0]    ch_rd;
  logic [AW-1:0]           rel;
  logic                    win_hit;
  logic                    hit_ena, hit_dis;

  assign hit_ena = bus_wr && (bus_addr == AW'(ADDR_ENA));
  assign hit_dis = bus_wr && (bus_addr == AW'(ADDR_DIS));
  assign rel     = bus_addr - AW'(WIN_BASE);
  assign win_hit = (32'(bus_addr) >= WIN_BASE) && (32'(bus_addr) < WIN_END);

  always_ff @(posedge clk) begin
    if (!rst_n)       ch_en <= '0;
    else if (hit_ena) ch_en <= ch_en | bus_wdata[NCH-1:0];
    else if (hit_dis) ch_en <= ch_en & ~bus_wdata[NCH-1:0];
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_wr;
      assign sel_wr = bus_wr && win_hit && (rel[AW-1:WIN_SHIFT] == IDXW'(i));
      pwm_chan #(.VARIANT(VARIANT), .DW(DW), .PRES_MAX(PRES_MAX)) u_chan (
        .clk(clk), .rst_n(rst_n), .run(ch_en[i]), .wr(sel_wr),
        .ofs(rel[WIN_SHIFT-1:0]), .wval(bus_wdata[DW-1:0]), .rdata(ch_rd[i]),
        .pwm_o(pwm_out[i]), .pol_o(ch_pol[i]), .wrap_o(ch_wrap[i]),
        .cnt_o(ch_cnt[i]), .prd_o(ch_prd[i])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_STAT)) bus_rdata[NCH-1:0] = ch_en;
    else if (win_hit) begin
      for (int i = 0; i < NCH; i++)
        if (rel[AW-1:WIN_SHIFT] == IDXW'(i)) bus_rdata = ch_rd[i];
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [NCH-1:0]         wr_mask,
  input logic [NCH-1:0]         stat_bits,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         ch_en,
  input logic [NCH-1:0]         ch_pol,
  input logic [NCH-1:0]         ch_wrap,
  input logic [NCH-1:0][DW-1:0] ch_cnt,
  input logic [NCH-1:0][DW-1:0] ch_prd
);
  logic w_ena, w_dis;
  assign w_ena = bus_wr && (bus_addr == AW'(ADDR_ENA));
  assign w_dis = bus_wr && (bus_addr == AW'(ADDR_DIS));

  p_ena_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_ena |=> (ch_en == ($past(ch_en) | $past(wr_mask))));

  p_dis_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_dis |=> (ch_en == ($past(ch_en) & ~$past(wr_mask))));

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_ena || w_dis) |=> $stable(ch_en));

  p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(ADDR_STAT)) |-> (stat_bits == ch_en));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[i] |-> (pwm_out[i] == ch_pol[i]));

      p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_en[i]) |-> (ch_cnt[i] == '0));

      p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_prd[i] != '0) |-> (ch_cnt[i] < ch_prd[i]));

      p_cnt_zero_prd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_prd[i] == '0) |-> (ch_cnt[i] == '0));

      p_prd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en[i] && !ch_wrap[i]) |=> $stable(ch_prd[i]));

      p_wrap_running_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ch_wrap[i] |-> ch_en[i]);
    end
  endgenerate
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_pwm_bank_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wr_mask(bus_wdata[NCH-1:0]), .stat_bits(bus_rdata[NCH-1:0]),
  .pwm_out(pwm_out), .ch_en(ch_en), .ch_pol(ch_pol), .ch_wrap(ch_wrap),
  .ch_cnt(ch_cnt), .ch_prd(ch_prd)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic [3:0]  out_a, out_b;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pwm_bank #(.VARIANT(1)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_a), .pwm_out(out_a));

  pwm_bank #(.VARIANT(2)) u_pwm_bank_v2 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_b), .pwm_out(out_b));

  function automatic logic [11:0] ch_addr(int ch, int ofs);
    return 12'(32'h200 + ch * 32 + ofs);
  endfunction

  function automatic logic [31:0] mode_val(int n, int pol, int tgt);
    return 32'(n | (pol << 9) | (tgt << 10));
  endfunction

  function automatic logic exp_lvl(int k, int n, int p, int d, int pol);
    int pe = (p == 0) ? 1 : p;
    int c  = (k >> n) % pe;
    return ((c >= d) ? 1'b1 : 1'b0) ^ pol[0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(bit bank_b, logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d;
    if (bank_b) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd_reg(bit bank_b, logic [11:0] a, output logic [31:0] v);
    addr = a; #1;
    v = bank_b ? rd_b : rd_a;
  endtask

  // Samples one output for nk cycles from the enable; optional write at cycle wr_k
  task automatic run_wave(bit bank_b, int ch, int n, int pol, int p0, int d0, int p1, int d1,
                          int wr_k, logic [11:0] wa, logic [31:0] wd, int nk, string tag);
    int  per = ((p0 == 0) ? 1 : p0) << n;
    int  swk = 1 << 30;
    logic act, exp;
    if (wr_k >= 0) swk = ((wr_k + 2 + per - 1) / per) * per;
    for (int k = 0; k < nk; k++) begin
      if (k == wr_k) begin
        addr = wa; wdata = wd;
        if (bank_b) wr_b = 1'b1; else wr_a = 1'b1;
      end
      #1;
      act = bank_b ? out_b[ch] : out_a[ch];
      exp = (k < swk) ? exp_lvl(k, n, p0, d0, pol) : exp_lvl(k - swk, n, p1, d1, pol);
      chk(tag, 32'(act), 32'(exp));
      @(negedge clk);
      wr_a = 1'b0; wr_b = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(0, 12'h008, v); chk("R4 status after reset", v, 0);
    rd_reg(1, 12'h008, v); chk("R4 status after reset v2", v, 0);
    chk("R7 outputs idle after reset", 32'({out_b, out_a}), 0);
    rd_reg(0, ch_addr(0, 4), v); chk("R9 duty after reset", v, 0);
  endtask

  task automatic t_enable_mask();
    logic [31:0] v;
    wr_reg(0, 12'h000, 1);   rd_reg(0, 12'h008, v); chk("R2 set ch0", v, 1);
    wr_reg(0, 12'h000, 2);   rd_reg(0, 12'h008, v); chk("R2 set ch1 keeps ch0", v, 3);
    wr_reg(0, 12'h000, 0);   rd_reg(0, 12'h008, v); chk("R2 zero bits no effect", v, 3);
    wr_reg(0, 12'h000, 'hC); rd_reg(0, 12'h008, v); chk("R4 all running", v, 'hF);
    wr_reg(0, 12'h004, 1);   rd_reg(0, 12'h008, v); chk("R3 clear ch0", v, 'hE);
    wr_reg(0, 12'h004, 0);   rd_reg(0, 12'h008, v); chk("R3 zero bits no effect", v, 'hE);
    wr_reg(0, 12'h004, 'hF); rd_reg(0, 12'h008, v); chk("R3 clear all", v, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr_reg(0, ch_addr(3, 0), 32'hFFFF_F605);
    rd_reg(0, ch_addr(3, 0), v); chk("R1 mode readback", v, 32'h605);
    #1; chk("R7 idle level follows polarity", 32'(out_a[3]), 1);
    wr_reg(0, ch_addr(3, 4), 32'h0001_2345);
    rd_reg(0, ch_addr(3, 4), v); chk("R8 duty truncated", v, 32'h2345);
    wr_reg(0, ch_addr(3, 8), 32'h000A_BCDE);
    rd_reg(0, ch_addr(3, 8), v); chk("R8 period truncated", v, 32'hBCDE);
    wr_reg(1, ch_addr(1, 12), 32'h55);
    rd_reg(1, ch_addr(1, 12), v); chk("R9 layout 2 period offset", v, 32'h55);
    wr_reg(0, ch_addr(3, 0), 0);
    #1; chk("R7 idle level normal", 32'(out_a[3]), 0);
  endtask

  task automatic t_basic_wave();
    wr_reg(0, ch_addr(0, 0), mode_val(0, 0, 0));
    wr_reg(0, ch_addr(0, 8), 5);
    wr_reg(0, ch_addr(0, 4), 2);
    wr_reg(0, 12'h000, 1);
    run_wave(0, 0, 0, 0, 5, 2, 5, 2, -1, 0, 0, 15, "R5 R6 p5 d2");
    wr_reg(0, 12'h004, 1);
    wr_reg(0, ch_addr(0, 0), mode_val(1, 1, 0));
    wr_reg(0, ch_addr(0, 8), 4);
    wr_reg(0, ch_addr(0, 4), 1);
    wr_reg(0, 12'h000, 1);
    run_wave(0, 0, 1, 1, 4, 1, 4, 1, -1, 0, 0, 24, "R5 R6 div2 inverted");
    wr_reg(0, 12'h004, 1);
    #1; chk("R7 stopped inverted output", 32'(out_a[0]), 1);
    wr_reg(0, ch_addr(0, 0), 0);
  endtask

  task automatic t_clamp();
    wr_reg(0, ch_addr(1, 0), mode_val(15, 0, 0));
    wr_reg(0, ch_addr(1, 8), 2);
    wr_reg(0, ch_addr(1, 4), 1);
    wr_reg(0, 12'h000, 2);
    run_wave(0, 1, 10, 0, 2, 1, 2, 1, -1, 0, 0, 2100, "R5 prescaler clamp");
    wr_reg(0, 12'h004, 2);
    wr_reg(0, ch_addr(1, 0), 0);
  endtask

  task automatic t_period_zero();
    wr_reg(0, ch_addr(2, 8), 0);
    wr_reg(0, ch_addr(2, 4), 0);
    wr_reg(0, 12'h000, 4);
    run_wave(0, 2, 0, 0, 0, 0, 0, 0, -1, 0, 0, 6, "R5 period zero");
    wr_reg(0, 12'h004, 4);
  endtask

  task automatic t_direct_ignored();
    logic [31:0] v;
    wr_reg(0, ch_addr(1, 8), 6);
    wr_reg(0, ch_addr(1, 4), 3);
    wr_reg(0, 12'h000, 2);
    wr_reg(0, ch_addr(1, 4), 1);
    wr_reg(0, ch_addr(1, 8), 9);
    rd_reg(0, ch_addr(1, 4), v); chk("R9 running duty write ignored", v, 3);
    rd_reg(0, ch_addr(1, 8), v); chk("R9 running period write ignored", v, 6);
    wr_reg(0, 12'h004, 2);
    wr_reg(0, 12'h000, 2);
    run_wave(0, 1, 0, 0, 6, 3, 6, 3, -1, 0, 0, 12, "R9 waveform unchanged");
    wr_reg(0, 12'h004, 2);
  endtask

  task automatic t_update_v1();
    logic [31:0] v;
    wr_reg(0, ch_addr(2, 0), mode_val(0, 0, 0));
    wr_reg(0, ch_addr(2, 8), 8);
    wr_reg(0, ch_addr(2, 4), 2);
    wr_reg(0, 12'h000, 4);
    run_wave(0, 2, 0, 0, 8, 2, 8, 6, 3, ch_addr(2, 16), 6, 24, "R10 R11 layout 1 duty update");
    wr_reg(0, 12'h004, 4);
    rd_reg(0, ch_addr(2, 4), v); chk("R11 duty after boundary", v, 6);
    wr_reg(0, ch_addr(2, 0), mode_val(0, 0, 1));
    wr_reg(0, 12'h000, 4);
    run_wave(0, 2, 0, 0, 8, 6, 12, 6, 10, ch_addr(2, 16), 12, 40, "R10 R11 layout 1 period update");
    wr_reg(0, 12'h004, 4);
    wr_reg(0, ch_addr(2, 16), 7);
    rd_reg(0, ch_addr(2, 8), v); chk("R11 stopped update immediate", v, 7);
    rd_reg(0, ch_addr(2, 4), v); chk("R10 target 1 leaves duty", v, 6);
  endtask

  task automatic t_update_v2();
    logic [31:0] v;
    wr_reg(1, ch_addr(3, 4), 1);
    wr_reg(1, ch_addr(3, 12), 4);
    wr_reg(1, 12'h000, 8);
    run_wave(1, 3, 0, 0, 4, 1, 4, 3, 5, ch_addr(3, 8), 3, 16, "R10 R11 layout 2 duty update");
    wr_reg(1, 12'h004, 8);
    rd_reg(1, ch_addr(3, 4), v); chk("R11 layout 2 duty after boundary", v, 3);
    wr_reg(1, 12'h000, 8);
    run_wave(1, 3, 0, 0, 4, 3, 6, 3, 2, ch_addr(3, 16), 6, 20, "R10 R11 layout 2 period update");
    wr_reg(1, ch_addr(3, 12), 9);
    rd_reg(1, ch_addr(3, 12), v); chk("R9 layout 2 running period ignored", v, 6);
    wr_reg(1, ch_addr(3, 4), 0);
    rd_reg(1, ch_addr(3, 4), v); chk("R9 layout 2 running duty ignored", v, 3);
    wr_reg(1, 12'h004, 8);
  endtask

  task automatic t_restart();
    wr_reg(0, ch_addr(0, 8), 6);
    wr_reg(0, ch_addr(0, 4), 2);
    wr_reg(0, 12'h000, 1);
    run_wave(0, 0, 0, 0, 6, 2, 6, 2, -1, 0, 0, 4, "R6 before stop");
    wr_reg(0, 12'h004, 1);
    #1; chk("R7 stopped normal output", 32'(out_a[0]), 0);
    wr_reg(0, ch_addr(0, 0), mode_val(0, 1, 0));
    #1; chk("R7 stopped output tracks polarity", 32'(out_a[0]), 1);
    wr_reg(0, 12'h000, 1);
    run_wave(0, 0, 0, 1, 6, 2, 6, 2, -1, 0, 0, 8, "R7 restart at count zero");
    wr_reg(0, 12'h004, 1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_mask();
    t_fields();
    t_basic_wave();
    t_clamp();
    t_period_zero();
    t_direct_ignored();
    t_update_v1();
    t_update_v2();
    t_restart();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 run did not complete actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule